// File: doc/BRIEF.md
# Dual-Slot Edge Capture Unit

This block watches one timer pin while that pin is set as an input and takes snapshots of a free-running counter into two capture slots. A two-flop synchronizer brings the pin into the clock domain. An edge detector then looks for edges of the selected polarity: rising only, falling only, or both. It can also be switched off. The first qualifying edge fills slot A and the second fills slot B. After that the unit ignores further edges until it is re-armed.

Software has two ways to re-arm the unit. It can acknowledge the capture status with a one-cycle `cap_ack_i` pulse, or it can move the capture mode from off to any active mode. A one-cycle interrupt request follows either the first or the second capture, as `irq_on_second_i` selects. Interrupt masking and status bits are kept downstream. The counter is an input to this block.

Top module: `gpc_dual_capture`

## Requirements
- R1: After reset both capture slots read zero and `cap_irq_o` is low.
- R2: With `cap_mode_i` = 0 (off), no edge changes either slot and no interrupt request is raised.
- R3: With `cap_mode_i` = 1, only low-to-high transitions of the synchronized pin are captured.
- R4: With `cap_mode_i` = 2, only high-to-low transitions of the synchronized pin are captured.
- R5: With `cap_mode_i` = 3, transitions in both directions are captured.
- R6: While `pin_is_input_i` is 0, edges are ignored and the slots keep their values.
- R7: After re-arm, the first captured edge writes slot A (`capture_a_o`) and the second writes slot B (`capture_b_o`). Any further edges are ignored until the unit is re-armed.
- R8: The stored value is `counter_i` as sampled at the third rising clock edge after the pin changes. This is two synchronizer stages plus the edge-detect register. The slot shows the new value after that same clock edge.
- R9: `cap_irq_o` is high for one cycle, in the cycle after the capture that fills slot A when `irq_on_second_i` = 0, or slot B when `irq_on_second_i` = 1.
- R10: A `cap_ack_i` pulse resets the capture count to zero. If a qualifying edge is seen in the same cycle as the pulse, that edge is stored in slot A.
- R11: A change of `cap_mode_i` from 0 to a nonzero value resets the capture count. A change between two active modes does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous timer pin level |
| pin_is_input_i | input | 1 | 1 when the pin is configured as an input |
| cap_mode_i | input | 2 | 0 off, 1 rising, 2 falling, 3 both |
| irq_on_second_i | input | 1 | 0: request after the first capture, 1: after the second |
| cap_ack_i | input | 1 | Pulse that acknowledges capture status and re-arms the unit |
| counter_i | input | CW | Running counter value |
| capture_a_o | output | CW | First capture slot |
| capture_b_o | output | CW | Second capture slot |
| cap_irq_o | output | 1 | One-cycle capture interrupt request |

## Verification
The edge-polarity assertions assume that the pin level is zero in the synchronizer during reset. This holds because the stages reset to zero, so the first post-reset comparison never sees a phantom edge. The interrupt-slot assertion assumes that `irq_on_second_i` is settled in the cycle that a capture is taken, which holds because it is a configuration input. The bench changes every input only just after the falling clock edge. Random phases change mode, direction and interrupt-slot selection rarely and toggle the pin often, so that captures and re-arms, including an acknowledge that arrives with an edge, happen within the intended one-change-per-cycle envelope.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_ANY  = 2'd3
  } cap_mode_e;

  localparam int unsigned CAP_SLOTS = 2;
endpackage

// File: rtl/gpc_sync.sv
module gpc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/gpc_edge_det.sv
module gpc_edge_det
  import gpc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      level_i,
  input  cap_mode_e mode_i,
  output logic      hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign rise = level_i & ~prev_q;
  assign fall = ~level_i & prev_q;

  always_comb begin
    unique case (mode_i)
      CAP_RISE: hit_o = rise;
      CAP_FALL: hit_o = fall;
      CAP_ANY:  hit_o = rise | fall;
      default:  hit_o = 1'b0;
    endcase
  end

  // R3: rising-only mode reacts to a low-to-high move of the level
  a_r3_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && mode_i == CAP_RISE) |-> (level_i && !$past(level_i)));
  // R4: falling-only mode reacts to a high-to-low move of the level
  a_r4_fall_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && mode_i == CAP_FALL) |-> (!level_i && $past(level_i)));
  // R5: any hit needs a level change
  a_r5_change_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (level_i != $past(level_i)));
endmodule

// File: rtl/gpc_cap_seq.sv
module gpc_cap_seq
  import gpc_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          dir_in_i,
  input  logic                          hit_i,
  input  cap_mode_e                     mode_i,
  input  logic                          irq_second_i,
  input  logic                          ack_i,
  input  logic [CW-1:0]                 count_i,
  output logic [CAP_SLOTS-1:0][CW-1:0]  cap_o,
  output logic                          irq_o
);
  localparam int unsigned CNT_W = $clog2(CAP_SLOTS + 1);

  cap_mode_e                     mode_q;
  logic [CNT_W-1:0]              count_q, cnt_base;
  logic [CAP_SLOTS-1:0][CW-1:0]  cap_q;
  logic                          rearm, take, irq_q;

  assign rearm    = ack_i | ((mode_q == CAP_OFF) & (mode_i != CAP_OFF));
  assign cnt_base = rearm ? '0 : count_q;
  assign take     = dir_in_i & hit_i & (cnt_base < CNT_W'(CAP_SLOTS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= CAP_OFF;
      count_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      mode_q  <= mode_i;
      count_q <= take ? cnt_base + CNT_W'(1) : cnt_base;
      irq_q   <= take & (cnt_base == {{(CNT_W-1){1'b0}}, irq_second_i});
    end
  end

  generate
    for (genvar i = 0; i < CAP_SLOTS; i++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              cap_q[i] <= '0;
        else if (take && cnt_base == CNT_W'(i))   cap_q[i] <= count_i;
      end
    end
  endgenerate

  assign cap_o = cap_q;
  assign irq_o = irq_q;

  // R6: pin as output freezes slots and blocks requests
  a_r6_output_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_in_i |=> ($stable(cap_q) && !irq_o));
  // R2: mode off freezes slots and blocks requests
  a_r2_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == CAP_OFF) |=> ($stable(cap_q) && !irq_o));
  // R7: a full unit without re-arm keeps its slots
  a_r7_full_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_W'(CAP_SLOTS) && !rearm) |=> $stable(cap_q));
  // R9: request follows the selected slot
  a_r9_irq_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (count_q == CNT_W'($past(irq_second_i)) + CNT_W'(1)));
  // R10: acknowledge leaves at most one capture counted
  a_r10_ack_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (count_q <= CNT_W'(1)));
endmodule

// File: rtl/gpc_dual_capture.sv
module gpc_dual_capture
  import gpc_pkg::*;
#(
  parameter int unsigned CW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_i,
  input  logic          pin_is_input_i,
  input  logic [1:0]    cap_mode_i,
  input  logic          irq_on_second_i,
  input  logic          cap_ack_i,
  input  logic [CW-1:0] counter_i,
  output logic [CW-1:0] capture_a_o,
  output logic [CW-1:0] capture_b_o,
  output logic          cap_irq_o
);
  cap_mode_e                    mode;
  logic                         pin_s, hit;
  logic [CAP_SLOTS-1:0][CW-1:0] caps;

  assign mode = cap_mode_e'(cap_mode_i);

  gpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  gpc_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (pin_s),
    .mode_i  (mode),
    .hit_o   (hit)
  );

  gpc_cap_seq #(.CW(CW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dir_in_i     (pin_is_input_i),
    .hit_i        (hit),
    .mode_i       (mode),
    .irq_second_i (irq_on_second_i),
    .ack_i        (cap_ack_i),
    .count_i      (counter_i),
    .cap_o        (caps),
    .irq_o        (cap_irq_o)
  );

  assign capture_a_o = caps[0];
  assign capture_b_o = caps[1];
endmodule

// File: tb/gpc_dual_capture_tb_top.sv
module gpc_dual_capture_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0, dir = 1'b0, second = 1'b0, ack = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] ctr = 32'h1000;
  logic [31:0] cap_a, cap_b;
  logic        irq;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gpc_dual_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .pin_is_input_i(dir),
    .cap_mode_i(mode), .irq_on_second_i(second), .cap_ack_i(ack),
    .counter_i(ctr), .capture_a_o(cap_a), .capture_b_o(cap_b), .cap_irq_o(irq)
  );

  always @(negedge clk) ctr <= ctr + 32'd1;

  // Reference model built from the requirements
  function automatic logic edge_hit(logic [1:0] md, logic pv, logic cu);
    case (md)
      2'd1:    return !pv && cu;
      2'd2:    return pv && !cu;
      2'd3:    return pv != cu;
      default: return 1'b0;
    endcase
  endfunction

  logic        m_s1, m_s2, m_prev, m_irq;
  logic [1:0]  m_mode, m_cnt, m_base;
  logic        m_take;
  logic [31:0] m_cap [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_irq <= 0;
      m_mode <= 0; m_cnt <= 0; m_cap[0] <= 0; m_cap[1] <= 0;
    end else begin
      m_base = (ack || (m_mode == 2'd0 && mode != 2'd0)) ? 2'd0 : m_cnt;
      m_take = dir && edge_hit(mode, m_prev, m_s2) && (m_base < 2'd2);
      m_s1 <= pin; m_s2 <= m_s1; m_prev <= m_s2; m_mode <= mode;
      m_irq <= m_take && (m_base == {1'b0, second});
      if (m_take) m_cap[m_base[0]] <= ctr;
      m_cnt <= m_take ? m_base + 2'd1 : m_base;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic nstep();
    @(negedge clk); #1;
  endtask

  task automatic drive_pin(input logic val, output logic [31:0] exp);
    pin = val;
    exp = ctr + 32'd2;
    repeat (3) nstep();
  endtask

  task automatic settle();
    repeat (4) nstep();
  endtask

  logic [31:0] e1, e2, hold_a, hold_b, dummy;

  initial begin
    repeat (3) nstep();
    chk("R1 slot A reset", cap_a, 0);
    chk("R1 slot B reset", cap_b, 0);
    chk("R1 irq reset", {31'd0, irq}, 0);
    rst_n = 1'b1;
    nstep();

    // R2: mode off, pin toggles
    dir = 1;
    drive_pin(1, dummy); drive_pin(0, dummy); settle();
    chk("R2 off slot A", cap_a, 0);
    chk("R2 off slot B", cap_b, 0);

    // R3/R7/R8/R9: rising mode, request after first
    mode = 2'd1; second = 0; nstep();
    drive_pin(1, e1);
    chk("R8 slot A value", cap_a, e1);
    chk("R9 irq after first", {31'd0, irq}, 1);
    nstep();
    chk("R9 irq one cycle", {31'd0, irq}, 0);
    drive_pin(0, dummy); settle();
    chk("R3 fall ignored", cap_b, 0);
    drive_pin(1, e2);
    chk("R7 second to slot B", cap_b, e2);
    chk("R9 no irq on second", {31'd0, irq}, 0);
    drive_pin(0, dummy); drive_pin(1, dummy); settle();
    chk("R7 third ignored A", cap_a, e1);
    chk("R7 third ignored B", cap_b, e2);

    // R11: active->active change does not re-arm
    mode = 2'd3; nstep();
    drive_pin(0, dummy); settle();
    chk("R11 no rearm A", cap_a, e1);
    chk("R11 no rearm B", cap_b, e2);

    // R10: acknowledge re-arms
    mode = 2'd1; ack = 1; nstep(); ack = 0;
    drive_pin(1, e1);
    chk("R10 slot A after ack", cap_a, e1);
    chk("R10 slot B kept", cap_b, e2);

    // R4/R11/R9: off then falling, request after second
    mode = 2'd0; nstep(); mode = 2'd2; second = 1; nstep();
    drive_pin(0, e1);
    chk("R11 rearm fills A", cap_a, e1);
    chk("R9 no irq on first", {31'd0, irq}, 0);
    drive_pin(1, dummy); settle();
    chk("R4 rise ignored", cap_b, e2);
    drive_pin(0, e2);
    chk("R4 fall to slot B", cap_b, e2);
    chk("R9 irq after second", {31'd0, irq}, 1);

    // R5: both edges
    mode = 2'd0; nstep(); mode = 2'd3; second = 0; nstep();
    drive_pin(1, e1);
    drive_pin(0, e2);
    chk("R5 rise to A", cap_a, e1);
    chk("R5 fall to B", cap_b, e2);

    // R6: pin as output
    ack = 1; dir = 0; nstep(); ack = 0;
    hold_a = cap_a; hold_b = cap_b;
    drive_pin(1, dummy); drive_pin(0, dummy); settle();
    chk("R6 output hold A", cap_a, hold_a);
    chk("R6 output hold B", cap_b, hold_b);
    chk("R6 no irq", {31'd0, irq}, 0);

    // Random phase against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 2) == 0) pin = ~pin;
      if ($urandom_range(0, 40) == 0) mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 60) == 0) dir = ~dir;
      if ($urandom_range(0, 80) == 0) second = ~second;
      ack = ($urandom_range(0, 25) == 0);
      nstep();
      chk("R8 random slot A", cap_a, m_cap[0]);
      chk("R7 random slot B", cap_b, m_cap[1]);
      chk("R9 random irq", {31'd0, irq}, {31'd0, m_irq});
    end
    ack = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule